// File: doc/BRIEF.md
# Iterative two-mode CORDIC engine

This block evaluates CORDIC micro-rotations one per clock on a single shared datapath. In vectoring mode it turns a vector with positive x until its y component reaches zero. It then reports the vector length, compensated for the CORDIC gain, and the angle atan(y/x) added to a start angle. In rotation mode it turns a vector by a given angle. Because the start vector is pre-multiplied by the inverse gain, a unit start vector of (1.0, 0) comes out as cos and sin of that angle.

Coordinates are signed Q16 values, so 65536 stands for 1.0. Angles are signed degrees scaled by 2^16. The number of micro-rotations per operation is programmable between 1 and 16.

Requests enter on a valid/ready port. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. The engine takes no new request while it iterates, or while a finished result is held because `out_ready` is low. A result stays on the output port until the edge where `out_valid` and `out_ready` are both high.

Top module: `cordic_engine`

## Requirements
- R1: With `in_mode`=0 (vectoring), x > 0 and `in_z`=0, `out_z`/65536 equals atan2(y, x) in degrees, positive for y > 0 and negative for y < 0. `out_mag`/65536 equals sqrt(x²+y²) within a relative error of 0.5 % when 16 iterations are run.
- R2: With `in_mode`=1 (rotation), start vector (65536, 0) and angle `in_z` within ±90°, `out_x` and `out_y` equal 65536·cos and 65536·sin of that angle within 100 LSB, for angles of either sign.
- R3: In vectoring mode the angle accumulator starts from `in_z`, so `out_z` is `in_z` plus the measured angle.
- R4: `out_valid` rises on the N-th rising edge after the accepting edge, where N is `iter_count` sampled at acceptance. The values 0 and anything above 16 are treated as 16.
- R5: `in_ready` is low from the edge after an acceptance until the result is delivered. A request presented while `in_ready` is low is ignored and does not change the result.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and all outputs hold their values. With `out_ready` high, `out_valid` is a one-cycle pulse per operation.
- R7: While `rst_n` is low, `in_ready` is 1, `out_valid` is 0 and `out_mag` is 0. A reset during an operation discards that operation.
- R8: `in_mode` is sampled at acceptance. Changing it during an operation has no effect on that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Engine can take a request |
| in_mode | input | 1 | 0 = vectoring, 1 = rotation |
| in_x | input | 32 | Start x, signed Q16 |
| in_y | input | 32 | Start y, signed Q16 |
| in_z | input | 32 | Start angle, degrees × 2^16 |
| iter_count | input | 5 | Micro-rotations per operation (0 or >16 means 16) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_x | output | 32 | Final x (cos in rotation mode) |
| out_y | output | 32 | Final y (sin in rotation mode) |
| out_z | output | 32 | Final angle accumulator |
| out_mag | output | 64 | Final x times the gain constant 39796 (magnitude × 2^16) |

## Verification
The bench builds the engine with its default parameters: 32-bit data, 16 fractional bits, a 16-entry angle table and the gain constant 39796. With these, the full 16-step convergence is reachable, as are the clamp of out-of-range iteration counts to 16 and a short 4-step run whose latency and coarse accuracy can be compared. Inputs of up to about fifty in Q16 are used. That range exercises the ratios y/x from 1 to 10, the 45° diagonal, random positive vectors, negative y, both rotation signs, a start angle, stalls on the output side, and requests arriving mid-operation.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  typedef enum logic {
    MODE_VECTOR = 1'b0,
    MODE_ROTATE = 1'b1
  } cordic_mode_e;

  // atan(2^-i) in degrees, scaled by 2^16
  function automatic logic signed [31:0] atan_deg_q16(input int idx);
    case (idx)
      0:  return 32'sd2949120;
      1:  return 32'sd1740967;
      2:  return 32'sd919879;
      3:  return 32'sd466945;
      4:  return 32'sd234378;
      5:  return 32'sd117303;
      6:  return 32'sd58666;
      7:  return 32'sd29334;
      8:  return 32'sd14667;
      9:  return 32'sd7333;
      10: return 32'sd3666;
      11: return 32'sd1833;
      12: return 32'sd916;
      13: return 32'sd458;
      14: return 32'sd229;
      15: return 32'sd114;
      default: return 32'sd0;
    endcase
  endfunction

endpackage

// File: rtl/cordic_ctrl.sv
module cordic_ctrl #(
  parameter int MAX_ITER = 16,
  parameter int CW       = $clog2(MAX_ITER + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [CW-1:0] iter_req,
  output logic          busy,
  output logic [CW-1:0] step_idx,
  output logic          last
);
  localparam logic [CW-1:0] LIM_MAX = CW'(MAX_ITER);

  logic [CW-1:0] lim_q;
  logic [CW-1:0] lim_d;

  always_comb begin
    if (iter_req == '0 || iter_req > LIM_MAX) lim_d = LIM_MAX;
    else                                      lim_d = iter_req;
  end

  assign last = busy && (step_idx == lim_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      step_idx <= '0;
      lim_q    <= LIM_MAX;
    end else if (accept) begin
      busy     <= 1'b1;
      step_idx <= '0;
      lim_q    <= lim_d;
    end else if (busy) begin
      if (last) begin
        busy     <= 1'b0;
        step_idx <= '0;
      end else begin
        step_idx <= step_idx + 1'b1;
      end
    end
  end

  // R4: the step counter never passes the sampled limit
  assert_step_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step_idx < lim_q));

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage
  import cordic_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 step,
  input  cordic_mode_e         mode,
  input  logic signed [DW-1:0] x0,
  input  logic signed [DW-1:0] y0,
  input  logic signed [DW-1:0] z0,
  input  logic [CW-1:0]        step_idx,
  output logic signed [DW-1:0] x_nx,
  output logic signed [DW-1:0] y_nx,
  output logic signed [DW-1:0] z_nx
);
  logic signed [DW-1:0] x_q, y_q, z_q;
  logic signed [DW-1:0] sh_x, sh_y, ang;
  cordic_mode_e         mode_q;
  logic                 plus_dir;

  always_comb begin
    sh_x = x_q >>> step_idx;
    sh_y = y_q >>> step_idx;
    ang  = DW'(atan_deg_q16(int'(step_idx)));
    if (mode_q == MODE_VECTOR) plus_dir = (y_q > 0);
    else                       plus_dir = (z_q < 0);
    if (plus_dir) begin
      x_nx = x_q + sh_y;
      y_nx = y_q - sh_x;
      z_nx = z_q + ang;
    end else begin
      x_nx = x_q - sh_y;
      y_nx = y_q + sh_x;
      z_nx = z_q - ang;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      mode_q <= MODE_VECTOR;
    end else if (load) begin
      x_q    <= x0;
      y_q    <= y0;
      z_q    <= z0;
      mode_q <= mode;
    end else if (step) begin
      x_q <= x_nx;
      y_q <= y_nx;
      z_q <= z_nx;
    end
  end

  // R8: the mode held for an operation cannot change while it iterates
  assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> $stable(mode_q));

endmodule

// File: rtl/cordic_out.sv
module cordic_out #(
  parameter int DW   = 32,
  parameter int GAIN = 39796
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   capture,
  input  logic                   out_ready,
  input  logic signed [DW-1:0]   x_in,
  input  logic signed [DW-1:0]   y_in,
  input  logic signed [DW-1:0]   z_in,
  output logic                   out_valid,
  output logic signed [DW-1:0]   out_x,
  output logic signed [DW-1:0]   out_y,
  output logic signed [DW-1:0]   out_z,
  output logic signed [2*DW-1:0] out_mag
);
  localparam int PW = 2 * DW;
  localparam logic signed [DW-1:0] GAIN_S = DW'(GAIN);

  logic signed [PW-1:0] prod;
  assign prod = PW'(x_in) * PW'(GAIN_S);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_z     <= '0;
      out_mag   <= '0;
    end else if (capture) begin
      out_valid <= 1'b1;
      out_x     <= x_in;
      out_y     <= y_in;
      out_z     <= z_in;
      out_mag   <= prod;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R6: a stalled result stays presented and unchanged
  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mag) && $stable(out_z)));

endmodule

// File: rtl/cordic_engine.sv
module cordic_engine
  import cordic_pkg::*;
#(
  parameter int DW       = 32,
  parameter int FRAC     = 16,
  parameter int MAX_ITER = 16,
  parameter int GAIN     = 39796
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic                               in_mode,
  input  logic signed [DW-1:0]               in_x,
  input  logic signed [DW-1:0]               in_y,
  input  logic signed [DW-1:0]               in_z,
  input  logic [$clog2(MAX_ITER+1)-1:0]      iter_count,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic signed [DW-1:0]               out_x,
  output logic signed [DW-1:0]               out_y,
  output logic signed [DW-1:0]               out_z,
  output logic signed [2*DW-1:0]             out_mag
);
  localparam int CW = $clog2(MAX_ITER + 1);
  localparam int PW = 2 * DW;
  localparam logic signed [DW-1:0] GAIN_S = DW'(GAIN);

  logic                 accept, busy, last;
  logic [CW-1:0]        step_idx;
  logic signed [PW-1:0] pre_x, pre_y;
  logic signed [DW-1:0] x0, y0, x_nx, y_nx, z_nx;
  cordic_mode_e         mode_in;

  assign mode_in  = cordic_mode_e'(in_mode);
  assign in_ready = !busy && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  // rotation mode: fold the inverse gain into the start vector
  assign pre_x = PW'(in_x) * PW'(GAIN_S);
  assign pre_y = PW'(in_y) * PW'(GAIN_S);
  assign x0 = (mode_in == MODE_ROTATE) ? pre_x[FRAC+DW-1:FRAC] : in_x;
  assign y0 = (mode_in == MODE_ROTATE) ? pre_y[FRAC+DW-1:FRAC] : in_y;

  cordic_ctrl #(.MAX_ITER(MAX_ITER), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .iter_req (iter_count),
    .busy     (busy),
    .step_idx (step_idx),
    .last     (last)
  );

  cordic_stage #(.DW(DW), .CW(CW)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .step     (busy),
    .mode     (mode_in),
    .x0       (x0),
    .y0       (y0),
    .z0       (in_z),
    .step_idx (step_idx),
    .x_nx     (x_nx),
    .y_nx     (y_nx),
    .z_nx     (z_nx)
  );

  cordic_out #(.DW(DW), .GAIN(GAIN)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (last),
    .out_ready (out_ready),
    .x_in      (x_nx),
    .y_in      (y_nx),
    .z_in      (z_nx),
    .out_valid (out_valid),
    .out_x     (out_x),
    .out_y     (out_y),
    .out_z     (out_z),
    .out_mag   (out_mag)
  );

  // R5: once a request is taken the port closes
  assert_closed_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R4: a result appears only as the last iteration finishes
  assert_valid_after_iter_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(busy));

  // R7: no result is presented while the iteration is still running
  assert_no_result_mid_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last && !out_valid) |=> !$rose(out_valid) || $past(last));

endmodule

// File: tb/cordic_engine_tb.sv
module cordic_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam real PI = 3.14159265358979;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic               in_mode = 1'b0;
  logic signed [31:0] in_x = '0, in_y = '0, in_z = '0;
  logic [4:0]         iter_count = 5'd16;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic signed [31:0] out_x, out_y, out_z;
  logic signed [63:0] out_mag;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cordic_engine u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_x(in_x), .in_y(in_y), .in_z(in_z),
    .iter_count(iter_count), .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_z(out_z), .out_mag(out_mag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%f expected=%f", req, what, act, exp);
    end
  endtask

  function automatic real absr(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  // present one request, return at the negedge where out_valid is seen
  task automatic launch(input bit mode, input int x, input int y, input int z,
                        input int n, output int lat);
    int guard = 0;
    @(negedge clk);
    in_mode = mode; in_x = x; in_y = y; in_z = z; iter_count = 5'(n);
    in_valid = 1'b1;
    while (!in_ready && guard < 100) begin @(negedge clk); guard++; end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 100) begin @(negedge clk); lat++; end
  endtask

  task automatic t_vector(input int x, input int y, input int z0, input int n,
                          input string req);
    int lat;
    real ea, em, aa, am, ta, tm;
    launch(1'b0, x, y, z0, n, lat);
    ea = z0 / 65536.0 + $atan2(real'(y), real'(x)) * 180.0 / PI;
    em = $sqrt(real'(x) * real'(x) + real'(y) * real'(y));
    aa = out_z / 65536.0;
    am = real'(out_mag) / 65536.0;
    ta = 114.6 * (2.0 ** (1 - n)) + 0.05;
    tm = em * (0.005 + 2.0 ** (4 - 2 * n)) + 32.0;
    check(absr(aa - ea) <= ta, req, "angle deg", aa, ea);
    check(absr(am - em) <= tm, req, "magnitude", am, em);
    check(lat == ((n == 0 || n > 16) ? 16 : n), "R4", "latency", lat,
          (n == 0 || n > 16) ? 16 : n);
    @(negedge clk);
    check(!out_valid, "R6", "single pulse", out_valid, 0);
  endtask

  task automatic t_rotate(input real deg);
    int lat;
    real ex, ey;
    launch(1'b1, 65536, 0, $rtoi(deg * 65536.0), 16, lat);
    ex = 65536.0 * $cos(deg * PI / 180.0);
    ey = 65536.0 * $sin(deg * PI / 180.0);
    check(absr(out_x - ex) <= 100.0, "R2", "cos", out_x, ex);
    check(absr(out_y - ey) <= 100.0, "R2", "sin", out_y, ey);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check(in_ready == 1'b1, "R7", "in_ready in reset", in_ready, 1);
    check(out_valid == 1'b0, "R7", "out_valid in reset", out_valid, 0);
    check(out_mag == 0, "R7", "out_mag in reset", real'(out_mag), 0);
  endtask

  task automatic t_reset_mid_run();
    @(negedge clk);
    in_mode = 1'b0; in_x = 65536; in_y = 65536; in_z = 0; iter_count = 5'd16;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R7", "ready after mid-run reset", in_ready, 1);
    rst_n = 1'b1;
    repeat (20) begin
      @(negedge clk);
      check(!out_valid, "R7", "discarded op gives no result", out_valid, 0);
    end
  endtask

  task automatic t_ignore_busy();
    int lat = 0;
    int pulses = 0;
    @(negedge clk);
    in_mode = 1'b0; in_x = 65536; in_y = 65536; in_z = 0; iter_count = 5'd16;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      check(in_ready == 1'b0, "R5", "ready low while busy", in_ready, 0);
      in_valid = 1'b1; in_mode = 1'b1; in_x = 12345; in_y = -777; in_z = 999999;
      @(negedge clk);
    end
    in_valid = 1'b0; in_mode = 1'b0;
    while (!out_valid && lat < 100) begin @(negedge clk); lat++; end
    check(absr(out_z / 65536.0 - 45.0) <= 0.06, "R8", "mode held, angle",
          out_z / 65536.0, 45.0);
    check(absr(real'(out_mag) / 65536.0 - 92681.9) <= 500.0, "R5",
          "ignored request left data intact", real'(out_mag) / 65536.0, 92681.9);
    repeat (25) begin
      @(negedge clk);
      if (out_valid) pulses++;
    end
    check(pulses == 0, "R5", "no extra result", pulses, 0);
  endtask

  task automatic t_stall();
    int lat;
    logic signed [63:0] held;
    out_ready = 1'b0;
    launch(1'b0, 3 * 65536, 4 * 65536, 0, 16, lat);
    held = out_mag;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(out_valid && out_mag == held, "R6", "held under stall",
            real'(out_mag), real'(held));
      check(!in_ready, "R6", "input closed under stall", in_ready, 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check(!out_valid, "R6", "released after handshake", out_valid, 0);
    check(in_ready, "R6", "input reopened", in_ready, 1);
    check(absr(real'(held) / 65536.0 - 5.0 * 65536) <= 5.0 * 65536 * 0.005 + 32,
          "R1", "3-4-5 magnitude", real'(held) / 65536.0, 5.0 * 65536);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog R4: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset_state();
    rst_n = 1'b1;
    // R1: 45 degree diagonal and y/x ratios 1..10
    t_vector(65536, 65536, 0, 16, "R1");
    for (int k = 1; k <= 10; k++) t_vector(65536, k * 65536, 0, 16, "R1");
    // R1: negative y gives a negative angle
    t_vector(4 * 65536, -3 * 65536, 0, 16, "R1");
    // R1: random positive inputs
    for (int k = 0; k < 20; k++)
      t_vector(int'($urandom_range(3284720, 16384)),
               int'($urandom_range(3284720, 0)), 0, 16, "R1");
    // R3: start angle is added
    t_vector(65536, 65536, 10 * 65536, 16, "R3");
    // R4: short run and clamping of out-of-range counts
    t_vector(65536, 65536, 0, 4, "R4");
    t_vector(65536, 2 * 65536, 0, 0, "R4");
    t_vector(2 * 65536, 65536, 0, 20, "R4");
    // R2: rotation of both signs
    t_rotate(30.0);
    t_rotate(-60.0);
    t_rotate(85.0);
    t_ignore_busy();
    t_stall();
    t_reset_mid_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule